// File: doc/BRIEF.md
# Bus Talk/Listen Address Recognizer

This block watches the command bytes an instrument bus controller sends while the attention line is asserted. It decides whether this device has been told to listen or to talk. The bus lines arrive raw and active-low. The block inverts them and carries them into the system clock domain through a synchronizer. It acts once per byte, on the asserting edge of the data-valid line. The low five bits of each command byte are compared with a device address set on switch inputs, and the next two bits say whether the byte is a listen or a talk address.

Two flags hold the result: listen-addressed and talk-addressed. Unaddress commands clear each flag separately. Interface clear clears both. A talk-only strap stops the device from ever being listen-addressed, while talk addressing still works. A one-cycle strobe marks each command byte that has been accepted. The handshake, the data transfer and the decoding of other commands are done by neighbouring logic.

Top module: `gpib_addr_recognizer`

## Requirements
- R1: Every bus line is active-low. The command byte is the bitwise inverse of `bus_dio_n`. Bit 7 of that byte is ignored.
- R2: A command byte with bits 6:5 = 01 and bits 4:0 equal to `sw_addr` (a listen address, 0x20 to 0x3E) sets `listen_addr`.
- R3: A command byte with bits 6:5 = 10 and bits 4:0 equal to `sw_addr` (a talk address, 0x40 to 0x5E) sets `talk_addr`.
- R4: A byte transferred while `bus_atn_n` is high changes neither flag and produces no `cmd_strobe`.
- R5: The unlisten byte 0x3F clears `listen_addr` and leaves `talk_addr` unchanged.
- R6: The untalk byte 0x5F, or a talk address whose bits 4:0 differ from `sw_addr`, clears `talk_addr` and leaves `listen_addr` unchanged.
- R7: A listen address whose bits 4:0 differ from `sw_addr` leaves both flags unchanged.
- R8: While `sw_talk_only` is 1, `listen_addr` stays 0. Talk addressing still works.
- R9: While `bus_ifc_n` is low (after synchronization), both flags are cleared, and this overrides any byte.
- R10: Each falling edge of `bus_dav_n` with `bus_atn_n` low gives exactly one `cmd_strobe` pulse, one cycle wide, however long `bus_dav_n` stays low. The flags and the strobe change on the third rising clock edge after the fall (with the default of two synchronizer stages).
- R11: While `rst_n` is low, `listen_addr`, `talk_addr` and `cmd_strobe` are 0.
- R12: Command bytes with bits 6:5 = 00 or 11 raise `cmd_strobe` but change neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_dio_n | input | 8 | Raw bus data lines, active low |
| bus_atn_n | input | 1 | Attention line, active low |
| bus_dav_n | input | 1 | Data-valid line, active low |
| bus_ifc_n | input | 1 | Interface clear line, active low |
| sw_addr | input | 5 | Device address switches |
| sw_talk_only | input | 1 | Talk-only strap; 1 blocks listen addressing |
| listen_addr | output | 1 | Device is listen-addressed |
| talk_addr | output | 1 | Device is talk-addressed |
| cmd_strobe | output | 1 | One-cycle pulse per accepted command byte |

## Verification
The block's internal state is just the two flags and the synchronized data-valid history, so a wrong state shows up at the ports almost at once. A wrong flag is visible on `listen_addr` or `talk_addr` three clocks after the byte that caused it, and it stays wrong until a later unaddress command or interface clear. A lost or repeated edge detection shows up as a missing or extra `cmd_strobe` pulse for that byte. The bench therefore counts strobes and compares both flags after every byte.

// File: rtl/gpib_addr_pkg.sv
package gpib_addr_pkg;
   typedef enum logic [2:0] {
      CMD_OTHER,
      CMD_LISTEN_ME,
      CMD_LISTEN_OTHER,
      CMD_UNLISTEN,
      CMD_TALK_ME,
      CMD_TALK_OTHER,
      CMD_UNTALK
   } cmd_kind_e;

   localparam logic [1:0] GRP_LISTEN = 2'b01;
   localparam logic [1:0] GRP_TALK   = 2'b10;
endpackage

// File: rtl/gpib_bus_sync.sv
module gpib_bus_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpib_bus_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] pipe [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= '0;
               else        pipe[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= '0;
               else        pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/gpib_edge_detect.sv
module gpib_edge_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise
);
   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign rise = level & ~level_q;

   // R10: a held level never yields a second event
   p_single_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && level) |=> (!rise || !$stable(level)) || !rise);
endmodule

// File: rtl/gpib_cmd_decode.sv
module gpib_cmd_decode
   import gpib_addr_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 5
) (
   input  logic [BYTE_W-1:0] cmd_byte,
   input  logic [ADDR_W-1:0] my_addr,
   output cmd_kind_e         kind
);
   localparam int GRP_LSB = ADDR_W;
   localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

   generate
      if (BYTE_W < ADDR_W + 2) begin : g_bad_width
         $error("gpib_cmd_decode: byte too narrow for address and group");
      end
   endgenerate

   logic [1:0]        grp;
   logic [ADDR_W-1:0] low;

   assign grp = cmd_byte[GRP_LSB+1:GRP_LSB];
   assign low = cmd_byte[ADDR_W-1:0];

   always_comb begin
      kind = CMD_OTHER;
      if (grp == GRP_LISTEN) begin
         if (low == ALL_ONES)     kind = CMD_UNLISTEN;
         else if (low == my_addr) kind = CMD_LISTEN_ME;
         else                     kind = CMD_LISTEN_OTHER;
      end else if (grp == GRP_TALK) begin
         if (low == ALL_ONES)     kind = CMD_UNTALK;
         else if (low == my_addr) kind = CMD_TALK_ME;
         else                     kind = CMD_TALK_OTHER;
      end
   end
endmodule

// File: rtl/gpib_addr_flags.sv
module gpib_addr_flags
   import gpib_addr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cmd_evt,
   input  cmd_kind_e kind,
   input  logic      ifc,
   input  logic      talk_only,
   output logic      listen_q,
   output logic      talk_q,
   output logic      strobe_q
);
   logic listen_d, talk_d;

   always_comb begin
      listen_d = listen_q;
      talk_d   = talk_q;
      if (cmd_evt) begin
         unique case (kind)
            CMD_LISTEN_ME:  listen_d = 1'b1;
            CMD_UNLISTEN:   listen_d = 1'b0;
            CMD_TALK_ME:    talk_d   = 1'b1;
            CMD_TALK_OTHER,
            CMD_UNTALK:     talk_d   = 1'b0;
            default: ;
         endcase
      end
      if (talk_only) listen_d = 1'b0;
      if (ifc) begin
         listen_d = 1'b0;
         talk_d   = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         listen_q <= 1'b0;
         talk_q   <= 1'b0;
         strobe_q <= 1'b0;
      end else begin
         listen_q <= listen_d;
         talk_q   <= talk_d;
         strobe_q <= cmd_evt;
      end
   end

   p_ifc_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ifc |=> (!listen_q && !talk_q));
   p_talk_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      talk_only |=> !listen_q);
   p_listen_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_evt && !ifc && !talk_only) |=> $stable(listen_q));
   p_talk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_evt && !ifc) |=> $stable(talk_q));
endmodule

// File: rtl/gpib_addr_recognizer.sv
module gpib_addr_recognizer
   import gpib_addr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_W      = 8,
   parameter int ADDR_W      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] bus_dio_n,
   input  logic              bus_atn_n,
   input  logic              bus_dav_n,
   input  logic              bus_ifc_n,
   input  logic [ADDR_W-1:0] sw_addr,
   input  logic              sw_talk_only,
   output logic              listen_addr,
   output logic              talk_addr,
   output logic              cmd_strobe
);
   localparam int BUNDLE_W = BYTE_W + 3;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("gpib_addr_recognizer: ADDR_W must be positive");
      end
   endgenerate

   logic [BUNDLE_W-1:0] raw_pos, sync_pos;
   logic [BYTE_W-1:0]   cmd_byte;
   logic                atn_s, dav_s, ifc_s, dav_rise, cmd_evt;
   cmd_kind_e           kind;

   // active-low bus lines become active-high before crossing
   assign raw_pos = {~bus_ifc_n, ~bus_dav_n, ~bus_atn_n, ~bus_dio_n};

   gpib_bus_sync #(.STAGES(SYNC_STAGES), .WIDTH(BUNDLE_W)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (raw_pos),
      .sync_out (sync_pos)
   );

   assign cmd_byte = sync_pos[BYTE_W-1:0];
   assign atn_s    = sync_pos[BYTE_W];
   assign dav_s    = sync_pos[BYTE_W+1];
   assign ifc_s    = sync_pos[BYTE_W+2];

   gpib_edge_detect u_dav_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (dav_s),
      .rise  (dav_rise)
   );

   assign cmd_evt = dav_rise & atn_s;

   gpib_cmd_decode #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_decode (
      .cmd_byte (cmd_byte),
      .my_addr  (sw_addr),
      .kind     (kind)
   );

   gpib_addr_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_evt   (cmd_evt),
      .kind      (kind),
      .ifc       (ifc_s),
      .talk_only (sw_talk_only),
      .listen_q  (listen_addr),
      .talk_q    (talk_addr),
      .strobe_q  (cmd_strobe)
   );

   p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe |=> !cmd_strobe);
   p_strobe_needs_atn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe |-> $past(atn_s));
   p_listen_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(listen_addr) |-> $past(dav_rise));
   p_talk_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(talk_addr) |-> $past(dav_rise && atn_s));
endmodule

// File: tb/gpib_addr_recognizer_tb.sv
module gpib_addr_recognizer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_dio_n = 8'hFF;
   logic       bus_atn_n = 1'b1;
   logic       bus_dav_n = 1'b1;
   logic       bus_ifc_n = 1'b1;
   logic [4:0] sw_addr = 5'd9;
   logic       sw_talk_only = 1'b0;
   logic       listen_addr, talk_addr, cmd_strobe;

   int n_checks = 0;
   int n_fail = 0;
   int strobes = 0;

   always #5 clk = ~clk;

   gpib_addr_recognizer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_dio_n(bus_dio_n), .bus_atn_n(bus_atn_n),
      .bus_dav_n(bus_dav_n), .bus_ifc_n(bus_ifc_n), .sw_addr(sw_addr),
      .sw_talk_only(sw_talk_only), .listen_addr(listen_addr),
      .talk_addr(talk_addr), .cmd_strobe(cmd_strobe)
   );

   always @(posedge clk) if (cmd_strobe) strobes <= strobes + 1;

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // present a byte, then pulse data-valid low for 'hold' cycles
   task automatic send(input logic atn, input logic [7:0] b, input int hold);
      @(negedge clk);
      bus_atn_n = ~atn;
      bus_dio_n = ~b;
      repeat (2) @(negedge clk);
      bus_dav_n = 1'b0;
      repeat (hold) @(negedge clk);
      bus_dav_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   // fields: [11] atn, [10:3] byte, [2] listen, [1] talk, [0] strobe
   localparam int NV = 15;
   localparam logic [11:0] VECS [NV] = '{
      {1'b1, 8'h29, 3'b101},  // R2 listen to me
      {1'b1, 8'h49, 3'b111},  // R3 talk to me
      {1'b0, 8'h3F, 3'b110},  // R4 no attention
      {1'b0, 8'h5F, 3'b110},  // R4 no attention
      {1'b1, 8'h2A, 3'b111},  // R7 other listener
      {1'b1, 8'h3F, 3'b011},  // R5 unlisten
      {1'b1, 8'h4A, 3'b001},  // R6 other talker
      {1'b1, 8'h29, 3'b101},  // R2
      {1'b1, 8'h49, 3'b111},  // R3
      {1'b1, 8'h5F, 3'b101},  // R6 untalk
      {1'b1, 8'h09, 3'b101},  // R12 group 00
      {1'b1, 8'h69, 3'b101},  // R12 group 11
      {1'b1, 8'hC9, 3'b111},  // R1 bit 7 ignored, talk
      {1'b1, 8'hBF, 3'b011},  // R1 bit 7 ignored, unlisten
      {1'b1, 8'hA9, 3'b111}   // R1 bit 7 ignored, listen
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int s0;
      // R11 reset state
      repeat (3) @(negedge clk);
      chk("R11 listen", listen_addr, 0);
      chk("R11 talk", talk_addr, 0);
      chk("R11 strobe", cmd_strobe, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         s0 = strobes;
         send(VECS[i][11], VECS[i][10:3], 5);
         chk($sformatf("vec%0d listen", i), listen_addr, int'(VECS[i][2]));
         chk($sformatf("vec%0d talk", i), talk_addr, int'(VECS[i][1]));
         chk($sformatf("vec%0d strobes", i), strobes - s0, int'(VECS[i][0]));
      end

      // R10 exact latency and single pulse on a long hold
      @(negedge clk);
      bus_atn_n = 1'b0;
      bus_dio_n = ~8'h3F;
      repeat (2) @(negedge clk);
      bus_dav_n = 1'b0;
      s0 = strobes;
      repeat (2) @(negedge clk);
      chk("R10 strobe before 3rd edge", cmd_strobe, 0);
      chk("R10 listen before 3rd edge", listen_addr, 1);
      @(negedge clk);
      chk("R10 strobe at 3rd edge", cmd_strobe, 1);
      chk("R10 listen at 3rd edge", listen_addr, 0);
      @(negedge clk);
      chk("R10 strobe width", cmd_strobe, 0);
      repeat (20) @(negedge clk);
      bus_dav_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R10 one strobe per byte", strobes - s0, 1);

      // R8 talk-only strap
      sw_talk_only = 1'b1;
      send(1'b1, 8'h5F, 5);
      send(1'b1, 8'h29, 5);
      chk("R8 listen blocked", listen_addr, 0);
      send(1'b1, 8'h49, 5);
      chk("R8 talk allowed", talk_addr, 1);
      chk("R8 listen still blocked", listen_addr, 0);
      sw_talk_only = 1'b0;
      send(1'b1, 8'h29, 5);
      chk("R2 listen after strap off", listen_addr, 1);

      // R9 interface clear
      @(negedge clk);
      bus_ifc_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R9 listen cleared", listen_addr, 0);
      chk("R9 talk cleared", talk_addr, 0);
      send(1'b1, 8'h29, 5);
      chk("R9 byte overridden", listen_addr, 0);
      bus_ifc_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R9 stays clear after release", talk_addr, 0);

      // R4 data byte during addressed state leaves flags
      send(1'b1, 8'h49, 5);
      s0 = strobes;
      send(1'b0, 8'h4A, 5);
      chk("R4 talk kept", talk_addr, 1);
      chk("R4 no strobe", strobes - s0, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule